// File: doc/BRIEF.md
# Cellular automaton keystream register

The block holds a ring of `N` one-bit cells that evolves under elementary rule 30 and produces one keystream bit per step. The keystream bit is taken from the cell at index `N/2`. On a step, each cell takes the value `left XOR (self OR right)` from the row before the step. The ring wraps around, so the two end cells are neighbours of each other.

A seed word is loaded synchronously and is also kept in a separate seed store. A replay request puts that stored seed back into the ring, so the same step sequence can be run again. A fault mask input inverts any chosen set of cells. If the mask arrives on a step cycle it acts on the row before the update. If no step is requested, the flipped row is simply written back. Comparing a faulted run with a clean replay of the same seed shows how a flipped cell spreads into the keystream.

Top module: `ca_keystream`

## Requirements
- R1: While `rst_n` is low, the ring and the seed store are cleared to all zeros, so `ks_bit` reads 0.
- R2: When `seed_load` is high, the next row equals `seed_in` and the seed store takes `seed_in`. This has priority over `replay`, `step` and `fault_mask`.
- R3: When `step` is high, and neither `seed_load` nor `replay` is high, cell i becomes p[(i-1) mod N] XOR (p[i] OR p[(i+1) mod N]). Here p is the current row XOR `fault_mask`.
- R4: `ks_bit` always equals the cell at index N/2 of the current row. With the default N = 16 this is cell 8.
- R5: When `replay` is high and `seed_load` is low, the next row equals the stored seed. This has priority over `step` and `fault_mask`. Steps and faults never change the seed store.
- R6: A nonzero `fault_mask` on a step cycle acts on the pre-update row: a set bit k inverts cell k before the rule is applied.
- R7: When `fault_mask` is nonzero and `seed_load`, `replay` and `step` are all low, the next row is the current row XOR `fault_mask`.
- R8: When all control inputs are low and `fault_mask` is zero, the row does not change.
- R9: A step from a pre-update row whose centre cell is 0 gives a centre output equal to the XOR of the two neighbours. A step from a row whose centre cell is 1, whether forced there by a fault or not, gives a centre output equal to the inverse of the left neighbour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load `seed_in` into the ring and the seed store |
| seed_in | input | N | Seed word |
| replay | input | 1 | Restore the ring from the stored seed |
| step | input | 1 | Advance the ring by one rule-30 generation |
| fault_mask | input | N | Set bits invert the matching cells |
| ks_bit | output | 1 | Keystream bit (centre cell) |

## Verification
The hard case is a fault on the centre or a neighbouring cell in the same cycle as a step. Only the one centre bit shows the result, so the check depends on the order of the fault and the update. Directed cases build seeds with a known neighbourhood around the centre and apply single-bit masks to the centre with and without a step. A random phase then mixes loads, replays, steps and faults. A bench model of the whole ring follows the same sequence, so any wrong cell surfaces at the centre over the following steps.

// File: rtl/ca_pkg.sv
package ca_pkg;
    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_LOAD   = 3'd1,
        OP_REPLAY = 3'd2,
        OP_STEP   = 3'd3,
        OP_FLIP   = 3'd4
    } ca_op_e;

    function automatic logic rule30(input logic l, input logic c, input logic r);
        return l ^ (c | r);
    endfunction
endpackage

// File: rtl/ca_cell.sv
module ca_cell
    import ca_pkg::*;
(
    input  logic left_i,
    input  logic self_i,
    input  logic right_i,
    output logic next_o
);
    assign next_o = rule30(left_i, self_i, right_i);
endmodule

// File: rtl/ca_seed_store.sv
module ca_seed_store #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] seed_i,
    output logic [N-1:0] seed_o
);
    logic [N-1:0] seed_d, seed_q;

    always_comb begin
        seed_d = seed_q;
        if (load_i) seed_d = seed_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seed_q <= '0;
        else        seed_q <= seed_d;
    end

    assign seed_o = seed_q;

    // R5
    seed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> seed_q == $past(seed_q));
endmodule

// File: rtl/ca_keystream.sv
module ca_keystream
    import ca_pkg::*;
#(
    parameter int N   = 16,
    parameter int CTR = N / 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed_load,
    input  logic [N-1:0] seed_in,
    input  logic         replay,
    input  logic         step,
    input  logic [N-1:0] fault_mask,
    output logic         ks_bit
);
    localparam int LAST = N - 1;

    typedef struct packed {
        logic [N-1:0] row;
    } ring_t;

    ring_t        st_d, st_q;
    ca_op_e       op;
    logic [N-1:0] seed_q;
    logic [N-1:0] pre_row;
    logic [N-1:0] stepped;

    initial begin
        if (N < 4) $error("ca_keystream: N must be at least 4");
    end

    ca_seed_store #(.N(N)) u_seed (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (seed_load),
        .seed_i (seed_in),
        .seed_o (seed_q)
    );

    assign pre_row = st_q.row ^ fault_mask;

    for (genvar i = 0; i < N; i++) begin : g_cell
        localparam int LI = (i == 0)    ? LAST : i - 1;
        localparam int RI = (i == LAST) ? 0    : i + 1;
        ca_cell u_cell (
            .left_i  (pre_row[LI]),
            .self_i  (pre_row[i]),
            .right_i (pre_row[RI]),
            .next_o  (stepped[i])
        );
    end

    always_comb begin
        if (seed_load)              op = OP_LOAD;
        else if (replay)            op = OP_REPLAY;
        else if (step)              op = OP_STEP;
        else if (|fault_mask)       op = OP_FLIP;
        else                        op = OP_HOLD;

        st_d = st_q;
        case (op)
            OP_LOAD:   st_d.row = seed_in;
            OP_REPLAY: st_d.row = seed_q;
            OP_STEP:   st_d.row = stepped;
            OP_FLIP:   st_d.row = pre_row;
            default:   st_d.row = st_q.row;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ks_bit = st_q.row[CTR];

    // R2
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> st_q.row == $past(seed_in));

    // R5
    replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (replay && !seed_load) |=> st_q.row == $past(seed_q));

    // R3
    step_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !seed_load && !replay) |=>
        ks_bit == $past(pre_row[CTR-1] ^ (pre_row[CTR] | pre_row[CTR+1])));

    // R7
    flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !replay && !step) |=> st_q.row == $past(st_q.row ^ fault_mask));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !replay && !step && fault_mask == '0) |=> $stable(st_q.row));
endmodule

// File: tb/tb_ca_keystream.sv
module tb_ca_keystream;
    localparam int N   = 16;
    localparam int CTR = N / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         seed_load = 1'b0;
    logic [N-1:0] seed_in = '0;
    logic         replay = 1'b0;
    logic         step = 1'b0;
    logic [N-1:0] fault_mask = '0;
    logic         ks_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [N-1:0] m_row  = '0;
    logic [N-1:0] m_seed = '0;

    always #10 clk = ~clk;

    ca_keystream #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_in(seed_in),
        .replay(replay), .step(step), .fault_mask(fault_mask), .ks_bit(ks_bit)
    );

    function automatic logic [N-1:0] next_gen(input logic [N-1:0] r);
        logic [N-1:0] o;
        for (int i = 0; i < N; i++) begin
            o[i] = r[(i + N - 1) % N] ^ (r[i] | r[(i + 1) % N]);
        end
        return o;
    endfunction

    function automatic logic [N-1:0] model_next(
        input logic [N-1:0] row, input logic [N-1:0] seed,
        input logic ld, input logic [N-1:0] sd, input logic rp,
        input logic st, input logic [N-1:0] fm);
        if (ld)       return sd;
        else if (rp)  return seed;
        else if (st)  return next_gen(row ^ fm);
        else          return row ^ fm;
    endfunction

    task automatic check_bit(input logic exp, input string tag);
        checks++;
        if (ks_bit !== exp) begin
            fails++;
            $display("FAIL %s: ks_bit=%0b expected=%0b", tag, ks_bit, exp);
        end
    endtask

    // Inputs set at negedge; edge applies them; compare at next negedge.
    task automatic cyc(input logic ld, input logic [N-1:0] sd, input logic rp,
                       input logic st, input logic [N-1:0] fm, input string tag);
        seed_load = ld; seed_in = sd; replay = rp; step = st; fault_mask = fm;
        @(posedge clk);
        m_row = model_next(m_row, m_seed, ld, sd, rp, st, fm);
        if (ld) m_seed = sd;
        @(negedge clk);
        seed_load = 0; replay = 0; step = 0; fault_mask = '0;
        check_bit(m_row[CTR], tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: expired, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] s;
        void'($urandom(32'h5eed_30ca));
        repeat (3) @(negedge clk);
        check_bit(1'b0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_bit(1'b0, "R1 after reset");

        // R2 load, centre set
        s = '0; s[CTR] = 1'b1;
        cyc(1, s, 0, 0, '0, "R2 load");
        // R4 single seed evolves
        for (int k = 0; k < 10; k++) cyc(0, '0, 0, 1, '0, "R3 R4 step");
        // R8 idle
        for (int k = 0; k < 3; k++) cyc(0, '0, 0, 0, '0, "R8 idle");
        // R5 replay restores seed
        cyc(0, '0, 1, 1, 16'hffff, "R5 replay priority");
        check_bit(1'b1, "R5 seed centre");
        // R2 load beats replay/step/fault
        cyc(1, 16'h0000, 1, 1, 16'hffff, "R2 load priority");

        // R9 centre 0, neighbours 1,1 -> 0
        s = '0; s[CTR-1] = 1; s[CTR+1] = 1;
        cyc(1, s, 0, 0, '0, "R2 load");
        cyc(0, '0, 0, 1, '0, "R9 xor equal");
        // R9 centre 0, neighbours 0,1 -> 1
        s = '0; s[CTR+1] = 1;
        cyc(1, s, 0, 0, '0, "R2 load");
        cyc(0, '0, 0, 1, '0, "R9 xor unequal");
        // R6 R9 centre faulted to 1 on step, left 1 -> 0
        s = '0; s[CTR-1] = 1;
        cyc(1, s, 0, 0, '0, "R2 load");
        cyc(0, '0, 0, 1, 16'h1 << CTR, "R6 R9 fault on step");
        // R9 centre faulted to 1, left 0 -> 1
        cyc(1, '0, 0, 0, '0, "R2 load");
        cyc(0, '0, 0, 1, 16'h1 << CTR, "R6 R9 fault on step left0");
        // R7 standalone flip of centre visible
        cyc(1, '0, 0, 0, '0, "R2 load");
        cyc(0, '0, 0, 0, 16'h1 << CTR, "R7 flip");
        cyc(0, '0, 0, 0, 16'h1 << CTR, "R7 flip back");
        // R3 wrap-around: only end cells set, step several times
        cyc(1, 16'h8001, 0, 0, '0, "R2 load");
        for (int k = 0; k < 12; k++) cyc(0, '0, 0, 1, '0, "R3 wrap");
        // R5 replay then same sequence again
        cyc(0, '0, 1, 0, '0, "R5 replay");
        for (int k = 0; k < 12; k++) cyc(0, '0, 0, 1, '0, "R5 R3 replayed run");

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            int r;
            logic ld, rp, st;
            logic [N-1:0] fm;
            r  = $urandom_range(99);
            ld = (r < 5);
            rp = (r >= 5 && r < 10);
            st = ($urandom_range(99) < 70);
            fm = ($urandom_range(99) < 20) ? N'(1) << $urandom_range(N-1) : '0;
            if ($urandom_range(99) < 5) fm = N'($urandom);
            cyc(ld, N'($urandom), rp, st, fm, "R3 R5 R6 R7 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule